// File: doc/BRIEF.md
# Set/Clear GPIO Port with Pin Function Muxing

A 32-pin general-purpose I/O port with a simple memory-mapped register bus. Software changes the output latch and the pin direction only through write-one-to-set and write-one-to-clear locations. A bit written as 0 leaves its pin alone, so no read-modify-write sequence is needed. The pin level that software reads back passes through a two-stage synchronizer.

Each pin has a two-bit function select. It routes the pad either to the GPIO latches or to one of three peripheral functions. A peripheral that owns a pin drives the pad's value and enable, and it sees the pad level on its own input. The pull resistor is enabled per pin and takes its direction from the output latch. A sleep input, qualified per pin by a keep mask, forces a pin back to a pulled input. The register file is combinational on reads and takes writes on the rising clock edge.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset all registers read 0. Every pin is then a GPIO input with its pull on and pulled low: pad_oe_o=0, pad_pull_en_o=all ones, pad_pull_up_o=0. All peripheral inputs are 0.
- R2: A write to offset 0x04 sets each output latch bit whose written bit is 1. A write to offset 0x08 clears each such bit. Bits written as 0 keep their value. Writes to offset 0x00 change nothing.
- R3: A write to offset 0x14 makes each pin with a 1 bit an output, and a write to offset 0x18 makes it an input. Writes to offset 0x10 change nothing. A read of 0x10 returns the direction mask, with 1 meaning output.
- R4: A read of offset 0x00 returns the pin levels as they were two rising edges earlier. After one edge the old level is still returned.
- R5: The pull-disable mask sits at offset 0x0C. For a pin that is not driven, a 1 bit turns its pull off and a 0 bit turns it on. pad_pull_up_o always equals the output latch, where 1 means pull-up and 0 means pull-down.
- R6: A pin whose pad enable is 1 never has its pull enabled.
- R7: Select masks A (offset 0x20) and B (offset 0x24) pick each pin's function as {B,A}: 00 is GPIO, 01 is function A, 10 is function B, 11 is function C.
- R8: For a pin in function A, B or C, the pad value and pad enable come from that function's alt_*_out_i and alt_*_oe_i bits. Only that function's alt_*_in_o bit carries the pad level; the other two read 0. In GPIO mode the pad takes the latch and direction.
- R9: While sleep_i is 1, a pin whose sleep-keep bit (offset 0x1C) is 0 is forced undriven with its pull on, whatever its mask bit. A pin whose keep bit is 1 keeps its configured state.
- R10: The masks at 0x0C, 0x1C, 0x20 and 0x24 read back as written. The set and clear offsets, and any unmapped offset, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 6 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data, bit n for pin n |
| bus_rdata_o | output | 32 | Read data, combinational |
| sleep_i | input | 1 | Sleep request |
| pad_in_i | input | 32 | Pad levels (asynchronous) |
| pad_out_o | output | 32 | Pad output value |
| pad_oe_o | output | 32 | Pad output enable |
| pad_pull_en_o | output | 32 | Pull resistor enable |
| pad_pull_up_o | output | 32 | Pull direction, 1 is up |
| alt_a_out_i | input | 32 | Function A output values |
| alt_a_oe_i | input | 32 | Function A output enables |
| alt_a_in_o | output | 32 | Function A pad inputs |
| alt_b_out_i | input | 32 | Function B output values |
| alt_b_oe_i | input | 32 | Function B output enables |
| alt_b_in_o | output | 32 | Function B pad inputs |
| alt_c_out_i | input | 32 | Function C output values |
| alt_c_oe_i | input | 32 | Function C output enables |
| alt_c_in_o | output | 32 | Function C pad inputs |

## Verification
A register write takes effect at the rising edge that samples it. The pad controls follow from the registers through logic only, so the bench drives a write at a falling edge and checks the pads at the next falling edge. Reads, peripheral routing and the sleep override are combinational, and the bench samples them 1 ns after changing their inputs. The synchronized pin level is due two rising edges after the pads change. The bench checks one edge after the change, expecting the old value, and again after the second edge, expecting the new one.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int unsigned REG_AW = 6;

  // function select, encoded as {sel_b, sel_a}
  typedef enum logic [1:0] {
    FN_GPIO = 2'b00,
    FN_A    = 2'b01,
    FN_B    = 2'b10,
    FN_C    = 2'b11
  } pin_fn_e;

  localparam logic [REG_AW-1:0] OFS_DAT   = 6'h00;
  localparam logic [REG_AW-1:0] OFS_DSET  = 6'h04;
  localparam logic [REG_AW-1:0] OFS_DCLR  = 6'h08;
  localparam logic [REG_AW-1:0] OFS_PDIS  = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_DIR   = 6'h10;
  localparam logic [REG_AW-1:0] OFS_DIRS  = 6'h14;
  localparam logic [REG_AW-1:0] OFS_DIRC  = 6'h18;
  localparam logic [REG_AW-1:0] OFS_KEEP  = 6'h1C;
  localparam logic [REG_AW-1:0] OFS_SELA  = 6'h20;
  localparam logic [REG_AW-1:0] OFS_SELB  = 6'h24;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_mux_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                we_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic [NUM_PINS-1:0] level_i,
  output logic [NUM_PINS-1:0] rdata_o,
  output logic [NUM_PINS-1:0] dat_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] pdis_o,
  output logic [NUM_PINS-1:0] keep_o,
  output logic [NUM_PINS-1:0] sela_o,
  output logic [NUM_PINS-1:0] selb_o
);
  logic                wr;
  logic [NUM_PINS-1:0] dat_q, dir_q, pdis_q, keep_q, sela_q, selb_q;

  assign wr = sel_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q  <= '0;
      dir_q  <= '0;
      pdis_q <= '0;
      keep_q <= '0;
      sela_q <= '0;
      selb_q <= '0;
    end else if (wr) begin
      unique case (addr_i)
        OFS_DSET: dat_q  <= dat_q | wdata_i;
        OFS_DCLR: dat_q  <= dat_q & ~wdata_i;
        OFS_DIRS: dir_q  <= dir_q | wdata_i;
        OFS_DIRC: dir_q  <= dir_q & ~wdata_i;
        OFS_PDIS: pdis_q <= wdata_i;
        OFS_KEEP: keep_q <= wdata_i;
        OFS_SELA: sela_q <= wdata_i;
        OFS_SELB: selb_q <= wdata_i;
        default:  ;  // data and direction words are read-only
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !we_i) begin
      unique case (addr_i)
        OFS_DAT:  rdata_o = level_i;
        OFS_DIR:  rdata_o = dir_q;
        OFS_PDIS: rdata_o = pdis_q;
        OFS_KEEP: rdata_o = keep_q;
        OFS_SELA: rdata_o = sela_q;
        OFS_SELB: rdata_o = selb_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign dat_o  = dat_q;
  assign dir_o  = dir_q;
  assign pdis_o = pdis_q;
  assign keep_o = keep_q;
  assign sela_o = sela_q;
  assign selb_o = selb_q;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_mux_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                sleep_i,
  input  logic [NUM_PINS-1:0] dat_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] pdis_i,
  input  logic [NUM_PINS-1:0] keep_i,
  input  logic [NUM_PINS-1:0] sela_i,
  input  logic [NUM_PINS-1:0] selb_i,
  input  logic [NUM_PINS-1:0] pad_in_i,
  input  logic [NUM_PINS-1:0] a_out_i,
  input  logic [NUM_PINS-1:0] a_oe_i,
  input  logic [NUM_PINS-1:0] b_out_i,
  input  logic [NUM_PINS-1:0] b_oe_i,
  input  logic [NUM_PINS-1:0] c_out_i,
  input  logic [NUM_PINS-1:0] c_oe_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pull_en_o,
  output logic [NUM_PINS-1:0] pull_up_o,
  output logic [NUM_PINS-1:0] a_in_o,
  output logic [NUM_PINS-1:0] b_in_o,
  output logic [NUM_PINS-1:0] c_in_o
);
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    pin_fn_e fn;
    logic    revert, oe, out;

    assign fn     = pin_fn_e'({selb_i[n], sela_i[n]});
    assign revert = sleep_i & ~keep_i[n];

    always_comb begin
      unique case (fn)
        FN_A:    begin oe = a_oe_i[n]; out = a_out_i[n]; end
        FN_B:    begin oe = b_oe_i[n]; out = b_out_i[n]; end
        FN_C:    begin oe = c_oe_i[n]; out = c_out_i[n]; end
        default: begin oe = dir_i[n];  out = dat_i[n];   end
      endcase
      if (revert) begin
        oe  = 1'b0;
        out = dat_i[n];
      end
    end

    assign pad_oe_o[n]  = oe;
    assign pad_out_o[n] = out;
    // sleep reversion forces the pull on regardless of the disable mask
    assign pull_en_o[n] = revert | (~oe & ~pdis_i[n]);
    assign pull_up_o[n] = dat_i[n];

    assign a_in_o[n] = (fn == FN_A) & pad_in_i[n];
    assign b_in_o[n] = (fn == FN_B) & pad_in_i[n];
    assign c_in_o[n] = (fn == FN_C) & pad_in_i[n];
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_sel_i,
  input  logic                bus_we_i,
  input  logic [REG_AW-1:0]   bus_addr_i,
  input  logic [NUM_PINS-1:0] bus_wdata_i,
  output logic [NUM_PINS-1:0] bus_rdata_o,
  input  logic                sleep_i,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_pull_en_o,
  output logic [NUM_PINS-1:0] pad_pull_up_o,
  input  logic [NUM_PINS-1:0] alt_a_out_i,
  input  logic [NUM_PINS-1:0] alt_a_oe_i,
  output logic [NUM_PINS-1:0] alt_a_in_o,
  input  logic [NUM_PINS-1:0] alt_b_out_i,
  input  logic [NUM_PINS-1:0] alt_b_oe_i,
  output logic [NUM_PINS-1:0] alt_b_in_o,
  input  logic [NUM_PINS-1:0] alt_c_out_i,
  input  logic [NUM_PINS-1:0] alt_c_oe_i,
  output logic [NUM_PINS-1:0] alt_c_in_o
);
  logic [NUM_PINS-1:0] level, dat_q, dir_q, pdis_q, keep_q, sela_q, selb_q;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (level)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (bus_sel_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .level_i (level),
    .rdata_o (bus_rdata_o),
    .dat_o   (dat_q),
    .dir_o   (dir_q),
    .pdis_o  (pdis_q),
    .keep_o  (keep_q),
    .sela_o  (sela_q),
    .selb_o  (selb_q)
  );

  gpio_pad_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .sleep_i   (sleep_i),
    .dat_i     (dat_q),
    .dir_i     (dir_q),
    .pdis_i    (pdis_q),
    .keep_i    (keep_q),
    .sela_i    (sela_q),
    .selb_i    (selb_q),
    .pad_in_i  (pad_in_i),
    .a_out_i   (alt_a_out_i),
    .a_oe_i    (alt_a_oe_i),
    .b_out_i   (alt_b_out_i),
    .b_oe_i    (alt_b_oe_i),
    .c_out_i   (alt_c_out_i),
    .c_oe_i    (alt_c_oe_i),
    .pad_out_o (pad_out_o),
    .pad_oe_o  (pad_oe_o),
    .pull_en_o (pad_pull_en_o),
    .pull_up_o (pad_pull_up_o),
    .a_in_o    (alt_a_in_o),
    .b_in_o    (alt_b_in_o),
    .c_in_o    (alt_c_in_o)
  );
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk
  import gpio_mux_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bus_sel_i,
  input logic                bus_we_i,
  input logic [REG_AW-1:0]   bus_addr_i,
  input logic [NUM_PINS-1:0] bus_wdata_i,
  input logic [NUM_PINS-1:0] bus_rdata_o,
  input logic                sleep_i,
  input logic [NUM_PINS-1:0] pad_in_i,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] pad_pull_en_o,
  input logic [NUM_PINS-1:0] alt_a_in_o,
  input logic [NUM_PINS-1:0] alt_b_in_o,
  input logic [NUM_PINS-1:0] alt_c_in_o,
  input logic [NUM_PINS-1:0] dat_q,
  input logic [NUM_PINS-1:0] dir_q,
  input logic [NUM_PINS-1:0] keep_q
);
  logic       wr, dset, dclr;
  logic [2:0] age_q;

  assign wr   = bus_sel_i & bus_we_i;
  assign dset = wr && (bus_addr_i == OFS_DSET);
  assign dclr = wr && (bus_addr_i == OFS_DCLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end

  assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dset |=> ((dat_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));
  assert_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dclr |=> ((dat_q & $past(bus_wdata_i)) == '0));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dset || dclr) |=> $stable(dat_q));
  assert_dirset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == OFS_DIRS) |=> ((dir_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));
  assert_dirclr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == OFS_DIRC) |=> ((dir_q & $past(bus_wdata_i)) == '0));
  assert_sync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q > 3'(SYNC_STAGES) && SYNC_STAGES == 2 && bus_sel_i && !bus_we_i && bus_addr_i == OFS_DAT)
      |-> (bus_rdata_o == $past(pad_in_i, 2)));
  assert_no_pull_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & pad_pull_en_o) == '0);
  assert_alt_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((alt_a_in_o & alt_b_in_o) | (alt_a_in_o & alt_c_in_o) | (alt_b_in_o & alt_c_in_o)) == '0);
  assert_sleep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (((pad_oe_o & ~keep_q) == '0) && ((~pad_pull_en_o & ~keep_q) == '0)));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_sel_i     (bus_sel_i),
  .bus_we_i      (bus_we_i),
  .bus_addr_i    (bus_addr_i),
  .bus_wdata_i   (bus_wdata_i),
  .bus_rdata_o   (bus_rdata_o),
  .sleep_i       (sleep_i),
  .pad_in_i      (pad_in_i),
  .pad_oe_o      (pad_oe_o),
  .pad_pull_en_o (pad_pull_en_o),
  .alt_a_in_o    (alt_a_in_o),
  .alt_b_in_o    (alt_b_in_o),
  .alt_c_in_o    (alt_c_in_o),
  .dat_q         (dat_q),
  .dir_q         (dir_q),
  .keep_q        (keep_q)
);

// File: tb/gpio_mux_port_test.sv
`timescale 1ns/1ps
module gpio_mux_port_test;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0, we = 1'b0, sleep = 1'b0;
  logic [5:0]    addr = '0;
  logic [N-1:0]  wdata = '0, rdata, pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe, pull_en, pull_up;
  logic [N-1:0]  a_out = '0, a_oe = '0, b_out = '0, b_oe = '0, c_out = '0, c_oe = '0;
  logic [N-1:0]  a_in, b_in, c_in;
  int            compared = 0, mismatched = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_mux_port uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .sleep_i(sleep), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pull_en_o(pull_en), .pad_pull_up_o(pull_up),
    .alt_a_out_i(a_out), .alt_a_oe_i(a_oe), .alt_a_in_o(a_in),
    .alt_b_out_i(b_out), .alt_b_oe_i(b_oe), .alt_b_in_o(b_in),
    .alt_c_out_i(c_out), .alt_c_oe_i(c_oe), .alt_c_in_o(c_in)
  );

  typedef struct packed {
    logic [5:0]  waddr;
    logic [31:0] wval;
    logic [5:0]  raddr;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{6'h14, 32'h0000FFFF, 6'h10, 32'h0000FFFF},  // R3 direction set
    '{6'h18, 32'h000000FF, 6'h10, 32'h0000FF00},  // R3 direction clear
    '{6'h10, 32'hFFFFFFFF, 6'h10, 32'h0000FF00},  // R3 direct write ignored
    '{6'h0C, 32'hA5A5A5A5, 6'h0C, 32'hA5A5A5A5},  // R10 pull-disable readback
    '{6'h1C, 32'h12345678, 6'h1C, 32'h12345678},  // R10 keep readback
    '{6'h20, 32'h0F0F0000, 6'h20, 32'h0F0F0000},  // R10 select A readback
    '{6'h24, 32'h00FF0000, 6'h24, 32'h00FF0000},  // R10 select B readback
    '{6'h04, 32'hDEADBEEF, 6'h04, 32'h00000000},  // R10 set location reads 0
    '{6'h30, 32'hFFFFFFFF, 6'h30, 32'h00000000}   // R10 unmapped reads 0
  };

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [N-1:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [N-1:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] rv;
    do_reset();

    // R1 reset state at the pads and in every register
    #1;
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pull_en", pull_en, '1);
    chk("R1 pull_up", pull_up, '0);
    chk("R1 alt inputs", a_in | b_in | c_in, '0);
    for (int k = 0; k <= 9; k++) begin
      bus_rd(6'(k * 4), rv);
      chk("R1 register read", rv, '0);
    end

    // table walk
    for (int i = 0; i < NV; i++) begin
      bus_wr(VECS[i].waddr, VECS[i].wval);
      bus_rd(VECS[i].raddr, rv);
      chk("R3/R10 table vector", rv, VECS[i].exp);
    end

    // R2 set/clear with all pins as GPIO outputs
    do_reset();
    bus_wr(6'h14, '1);
    bus_wr(6'h04, 32'h0000F00F);
    chk("R2 set", pad_out, 32'h0000F00F);
    chk("R6 no pull while driving", pull_en, '0);
    bus_wr(6'h08, 32'h0000000F);
    chk("R2 clear", pad_out, 32'h0000F000);
    bus_wr(6'h00, '1);
    chk("R2 data write ignored", pad_out, 32'h0000F000);
    bus_wr(6'h04, '0);
    chk("R2 zero set bits", pad_out, 32'h0000F000);

    // R5 pull control on inputs
    bus_wr(6'h18, '1);
    bus_wr(6'h0C, 32'hFFFF0000);
    chk("R5 pull enable", pull_en, 32'h0000FFFF);
    chk("R5 pull direction", pull_up, 32'h0000F000);
    chk("R3 inputs undriven", pad_oe, '0);

    // R4 two-edge synchronizer
    @(negedge clk);
    pad_in = 32'h13572468;
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = 6'h00;
    #1 chk("R4 one edge old level", rdata, '0);
    @(negedge clk);
    #1 chk("R4 two edges new level", rdata, 32'h13572468);
    sel = 1'b0;

    // R7 R8 function routing: pin0 A, pin1 B, pin2 C, pin3 GPIO
    do_reset();
    bus_wr(6'h20, 32'h5);
    bus_wr(6'h24, 32'h6);
    @(negedge clk);
    a_out = '1; a_oe = '1; b_out = '0; b_oe = '1; c_out = '1; c_oe = '0;
    pad_in = '1;
    #1;
    chk("R8 pad enable by function", pad_oe & 32'hF, 32'h3);
    chk("R8 pad value by function", pad_out & 32'hF, 32'h5);
    chk("R7 function A input", a_in, 32'h1);
    chk("R7 function B input", b_in, 32'h2);
    chk("R7 function C input", c_in, 32'h4);
    chk("R6 pull on undriven alt pin", pull_en & 32'hF, 32'hC);
    a_out = '0; a_oe = '0; b_oe = '0; c_out = '0; pad_in = '0;

    // R9 sleep reversion
    do_reset();
    bus_wr(6'h14, 32'hFF);
    bus_wr(6'h04, 32'hF0);
    bus_wr(6'h1C, 32'h0F);
    bus_wr(6'h0C, 32'hFF);
    @(negedge clk);
    sleep = 1'b1;
    #1;
    chk("R9 sleep drive", pad_oe & 32'hFF, 32'h0F);
    chk("R9 sleep pull", pull_en & 32'hFF, 32'hF0);
    chk("R9 sleep pull direction", pull_up & 32'hFF, 32'hF0);
    @(negedge clk);
    sleep = 1'b0;
    #1 chk("R9 wake restores", pad_oe & 32'hFF, 32'hFF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule